// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block lets a master reach a 16-bit register space that is not directly mapped, using only a small mailbox of 32-bit registers. A caller hands it one read or write with a target address and, for a write, a 16-bit value. The block then issues the mailbox accesses in order.

For a write, the block issues three mailbox writes and finishes. For a read, it issues two mailbox writes and then reads the status mailbox repeatedly. It stops when the word reports ready or when the poll budget runs out. It then decodes the two-bit response status and returns either the 16-bit data or 0xFFFF with an error code.

Each mailbox access is a single-outstanding request that is held until it is acknowledged. While an operation is in flight, `busy` is high and new requests are ignored. Completion is a one-cycle `done` pulse, with the data and error code valid in the same cycle.

Top module: `ind_reg_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done` and `mb_req` are all low.
- R2: The first mailbox access of every operation is a write (`mb_we`=1) to selector 0, the address mailbox. Its data is the request address shifted right by one, plus 0x30000.
- R3: A write operation issues exactly three mailbox writes, in this order: selector 0 (converted address), selector 1 (`{16'h0, data}`) and selector 2 (command value 1). No status read follows, and `done` rises with error 0.
- R4: A read operation issues a write to selector 0, then a write of command value 2 to selector 2. It then issues reads (`mb_we`=0) of selector 3, the status mailbox.
- R5: `mb_req`, `mb_sel`, `mb_we` and `mb_wdata` hold steady until `mb_ack`. Each cycle with `mb_req` and `mb_ack` both high completes exactly one access.
- R6: Bit 18 of the status word is the ready flag, and polling stops at the first word that has it set. If that word's status field (bits 17:16) is 1, `rsp_data` is bits 15:0 of the word and `rsp_err` is 0. Status bits in words without ready are ignored.
- R7: At most 32 status reads are issued. If none of them shows ready, the result is `rsp_err`=1 (timeout) with `rsp_data`=0xFFFF. Ready on the 32nd read still succeeds.
- R8: A ready word with status 0 gives `rsp_err`=1, status 2 gives `rsp_err`=2, and status 3 gives `rsp_err`=3. In each of these cases `rsp_data` is 0xFFFF.
- R9: `done` is a one-cycle pulse in the cycle after the acknowledge of the final access. `busy` is low in that cycle, and a request presented in that cycle is accepted.
- R10: A request presented while `busy` is high has no effect. It causes no mailbox access and does not change the running operation or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when `busy` is low |
| req_write | input | 1 | 1 = write operation, 0 = read operation |
| req_addr | input | 16 | Target register address |
| req_wdata | input | 16 | Data for a write operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Read data, or 0xFFFF on error, valid with `done` |
| rsp_err | output | 2 | 0 none, 1 timeout, 2 request failed, 3 response error |
| mb_req | output | 1 | Mailbox access request |
| mb_we | output | 1 | Mailbox access is a write |
| mb_sel | output | 2 | Mailbox selector: 0 address, 1 write data, 2 command, 3 status |
| mb_wdata | output | 32 | Mailbox write word |
| mb_ack | input | 1 | Mailbox access acknowledge |
| mb_rdata | input | 32 | Mailbox read word, sampled with `mb_ack` |

## Verification
The completion pulse of one operation and the acceptance of the next can fall in the same cycle, because `busy` drops exactly when `done` rises. The bench issues every following request in the very cycle it expects `done`. This exercises the overlap on zero-latency and delayed acknowledges alike. A cycle-level model then judges the pair: it expects the old result on `rsp_data`/`rsp_err` in that cycle, and it expects the new operation's address write to appear on the next mailbox access with no lost or duplicated access.

// File: rtl/ind_reg_pkg.sv
package ind_reg_pkg;
  localparam int MB_DW   = 32;
  localparam int RDY_BIT = 18;
  localparam int STS_LO  = 16;

  typedef enum logic [1:0] {
    MB_ADDR  = 2'd0,
    MB_WDATA = 2'd1,
    MB_CMD   = 2'd2,
    MB_STAT  = 2'd3
  } mb_sel_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_FAILED  = 2'd2,
    ERR_RESP    = 2'd3
  } err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WDATA, ST_CMD, ST_POLL
  } st_e;

  localparam logic [MB_DW-1:0] CMD_WRITE = 32'd1;
  localparam logic [MB_DW-1:0] CMD_READ  = 32'd2;

  // halve the target address and move it into the indirect window
  function automatic logic [MB_DW-1:0] conv_addr(input logic [MB_DW-1:0] a,
                                                 input logic [MB_DW-1:0] ofs);
    return (a >> 1) + ofs;
  endfunction

  // map the two-bit response status onto the result error code
  function automatic err_e sts_to_err(input logic [1:0] s);
    case (s)
      2'd1:    return ERR_NONE;
      2'd2:    return ERR_FAILED;
      2'd3:    return ERR_RESP;
      default: return ERR_TIMEOUT;
    endcase
  endfunction
endpackage

// File: rtl/irs_addr_xlate.sv
module irs_addr_xlate
  import ind_reg_pkg::*;
#(
  parameter int               ADDR_W = 16,
  parameter logic [MB_DW-1:0] OFFSET = 32'h30000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [MB_DW-1:0]  mb_addr
);
  assign mb_addr = conv_addr(MB_DW'(addr), OFFSET);
endmodule

// File: rtl/irs_status_decode.sv
module irs_status_decode
  import ind_reg_pkg::*;
(
  input  logic [MB_DW-1:0] word,
  output logic             ready,
  output logic [1:0]       err,
  output logic [15:0]      data
);
  err_e e;
  assign ready = word[RDY_BIT];
  assign e     = sts_to_err(word[STS_LO+1:STS_LO]);
  assign err   = e;
  assign data  = (e == ERR_NONE) ? word[15:0] : 16'hFFFF;
endmodule

// File: rtl/irs_poll_counter.sv
module irs_poll_counter #(
  parameter int POLL_MAX = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int CW = $clog2(POLL_MAX + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(POLL_MAX - 1));

  // R7
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt < CW'(POLL_MAX)));
endmodule

// File: rtl/ind_reg_seq.sv
module ind_reg_seq
  import ind_reg_pkg::*;
#(
  parameter int               ADDR_W      = 16,
  parameter int               POLL_MAX    = 32,
  parameter logic [MB_DW-1:0] ADDR_OFFSET = 32'h30000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rsp_data,
  output logic [1:0]        rsp_err,
  output logic              mb_req,
  output logic              mb_we,
  output logic [1:0]        mb_sel,
  output logic [MB_DW-1:0]  mb_wdata,
  input  logic              mb_ack,
  input  logic [MB_DW-1:0]  mb_rdata
);
  st_e              st;
  logic             op_write;
  logic [MB_DW-1:0] op_addr;
  logic [15:0]      op_data;
  logic [MB_DW-1:0] xl_addr;
  logic             dec_ready;
  logic [1:0]       dec_err;
  logic [15:0]      dec_data;
  logic             poll_last;

  // named events
  logic accept, acc_fire, cmd_done, poll_hit, finish_wr, finish_rd;
  assign accept    = req_valid && (st == ST_IDLE);
  assign acc_fire  = mb_req && mb_ack;
  assign cmd_done  = (st == ST_CMD) && acc_fire;
  assign poll_hit  = (st == ST_POLL) && acc_fire;
  assign finish_wr = cmd_done && op_write;
  assign finish_rd = poll_hit && (dec_ready || poll_last);

  irs_addr_xlate #(.ADDR_W(ADDR_W), .OFFSET(ADDR_OFFSET)) u_xlate (
    .addr(req_addr), .mb_addr(xl_addr));

  irs_status_decode u_dec (
    .word(mb_rdata), .ready(dec_ready), .err(dec_err), .data(dec_data));

  irs_poll_counter #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk(clk), .rst_n(rst_n), .clear(cmd_done), .step(poll_hit), .last(poll_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op_write <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st       <= ST_ADDR;
          op_write <= req_write;
          op_addr  <= xl_addr;
          op_data  <= req_wdata;
        end
        ST_ADDR:  if (acc_fire) st <= op_write ? ST_WDATA : ST_CMD;
        ST_WDATA: if (acc_fire) st <= ST_CMD;
        ST_CMD:   if (acc_fire) st <= op_write ? ST_IDLE : ST_POLL;
        ST_POLL:  if (finish_rd) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      rsp_data <= '0;
      rsp_err  <= ERR_NONE;
    end else begin
      done <= finish_wr || finish_rd;
      if (finish_wr) begin
        rsp_data <= 16'h0000;
        rsp_err  <= ERR_NONE;
      end else if (finish_rd) begin
        rsp_data <= dec_ready ? dec_data : 16'hFFFF;
        rsp_err  <= dec_ready ? dec_err  : ERR_TIMEOUT;
      end
    end
  end

  assign busy   = (st != ST_IDLE);
  assign mb_req = (st != ST_IDLE);
  assign mb_we  = (st != ST_POLL);

  always_comb begin
    mb_sel   = MB_ADDR;
    mb_wdata = '0;
    case (st)
      ST_ADDR:  begin mb_sel = MB_ADDR;  mb_wdata = op_addr; end
      ST_WDATA: begin mb_sel = MB_WDATA; mb_wdata = {16'h0000, op_data}; end
      ST_CMD:   begin mb_sel = MB_CMD;   mb_wdata = op_write ? CMD_WRITE : CMD_READ; end
      ST_POLL:  begin mb_sel = MB_STAT;  mb_wdata = '0; end
      default:  ;
    endcase
  end

  // R5
  mb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_req && !mb_ack) |=> (mb_req && $stable(mb_sel) && $stable(mb_we) && $stable(mb_wdata)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  err_ffff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_err != 2'd0) |-> (rsp_data == 16'hFFFF));
  // R3
  wr_no_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_write) |-> (mb_sel != MB_STAT));
  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/ind_reg_seq_bench.sv
module ind_reg_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        busy, done, mb_req, mb_we, mb_ack = 1'b0;
  logic [15:0] rsp_data;
  logic [1:0]  rsp_err, mb_sel;
  logic [31:0] mb_wdata, mb_rdata = '0;

  always #4 clk = ~clk; // 125 MHz

  ind_reg_seq u_ind_reg_seq (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  // entry: {compare_data, sel[1:0], we, wdata[31:0]}
  logic [35:0] q[$];
  string       q_tag[$];
  bit          model_busy = 0, pend_accept = 0, pend_final = 0, saw_done = 0;
  int          cur_lat = 0, lat_cnt = 0, cur_nrdy = 0, poll_idx = 0;
  logic [1:0]  cur_sts = 0;
  logic [15:0] cur_rd = 0, exp_data = 0;
  logic [1:0]  exp_err = 0;
  string       exp_tag = "";

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic tick();
    bit exp_done;
    @(negedge clk);
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'd100000);
      finish_run();
    end
    exp_done = 0;
    if (pend_accept) model_busy = 1;
    if (pend_final) begin model_busy = 0; exp_done = 1; end
    pend_accept = 0; pend_final = 0; saw_done = exp_done;
    req_valid = 1'b0;
    // R9 busy and done at the cycle-accurate positions
    chk(busy == model_busy, "R9 busy", 32'(busy), 32'(model_busy));
    chk(done == exp_done, "R9 done", 32'(done), 32'(exp_done));
    if (exp_done) begin
      chk(rsp_data == exp_data, {exp_tag, " data"}, 32'(rsp_data), 32'(exp_data));
      chk(rsp_err == exp_err, {exp_tag, " err"}, 32'(rsp_err), 32'(exp_err));
    end
    // mailbox responder
    mb_ack = 1'b0;
    if (mb_req) begin
      if (lat_cnt > 0) lat_cnt--;
      else begin
        logic [35:0] e;
        string t;
        mb_ack = 1'b1;
        lat_cnt = cur_lat;
        if (mb_sel == 2'd3) begin
          if (poll_idx < cur_nrdy) mb_rdata = {13'h0, 1'b0, 2'b01, 16'hA5A5 ^ 16'(poll_idx)};
          else                     mb_rdata = {13'h0, 1'b1, cur_sts, cur_rd};
          poll_idx++;
        end else mb_rdata = 32'hDEAD_0000;
        if (q.size() == 0) chk(1'b0, "R5 extra access", {30'h0, mb_sel}, 32'hFFFF_FFFF);
        else begin
          e = q.pop_front(); t = q_tag.pop_front();
          chk(mb_sel == e[34:33], {t, " sel"}, 32'(mb_sel), 32'(e[34:33]));
          chk(mb_we == e[32], {t, " we"}, 32'(mb_we), 32'(e[32]));
          if (e[35]) chk(mb_wdata == e[31:0], {t, " wdata"}, mb_wdata, e[31:0]);
          if (q.size() == 0) pend_final = 1;
        end
      end
    end
  endtask

  task automatic issue(bit wr, logic [15:0] a, logic [15:0] d, int lat,
                       int nrdy, logic [1:0] sts, string tag);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (model_busy || pend_accept) return; // R10: ignored, nothing queued
    pend_accept = 1;
    cur_lat = lat; lat_cnt = lat; cur_nrdy = nrdy; cur_sts = sts; cur_rd = d; poll_idx = 0;
    q.push_back({1'b1, 2'd0, 1'b1, (32'(a) >> 1) + 32'h30000}); q_tag.push_back("R2 addr");
    if (wr) begin
      q.push_back({1'b1, 2'd1, 1'b1, 16'h0, d}); q_tag.push_back("R3 wdata");
      q.push_back({1'b1, 2'd2, 1'b1, 32'd1});    q_tag.push_back("R3 cmd");
      exp_data = 16'h0000; exp_err = 2'd0; exp_tag = "R3";
    end else begin
      int np;
      q.push_back({1'b1, 2'd2, 1'b1, 32'd2}); q_tag.push_back("R4 cmd");
      np = (nrdy >= 32) ? 32 : nrdy + 1;
      for (int i = 0; i < np; i++) begin
        q.push_back({1'b0, 2'd3, 1'b0, 32'h0}); q_tag.push_back("R4 poll");
      end
      if (nrdy >= 32)     begin exp_data = 16'hFFFF; exp_err = 2'd1; exp_tag = "R7"; end
      else if (sts == 2'd1) begin exp_data = d; exp_err = 2'd0; exp_tag = "R6"; end
      else begin
        exp_data = 16'hFFFF; exp_err = (sts == 2'd0) ? 2'd1 : sts; exp_tag = "R8";
      end
    end
  endtask

  task automatic wait_done();
    do tick(); while (!saw_done);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mb_req, "R1 in reset", {busy, done, mb_req}, 32'h0);
    rst_n = 1'b1;
    tick();
    chk(!busy && !done && !mb_req, "R1 after reset", {busy, done, mb_req}, 32'h0);

    issue(1, 16'h1235, 16'hBEEF, 0, 0, 0, "w");  wait_done();
    // every next issue lands in the done cycle (R9 overlap)
    issue(1, 16'hFFFF, 16'h0001, 2, 0, 0, "w");  wait_done();
    issue(0, 16'h0040, 16'h1234, 0, 0, 2'd1, "r"); wait_done();
    issue(0, 16'h0003, 16'h5678, 1, 5, 2'd1, "r"); wait_done();
    issue(0, 16'h8000, 16'h9ABC, 0, 31, 2'd1, "r"); wait_done(); // R7 last poll ok
    issue(0, 16'h0010, 16'h1111, 0, 32, 2'd1, "r"); wait_done(); // R7 timeout
    repeat (3) tick();
    issue(0, 16'h0011, 16'h2222, 2, 40, 2'd1, "r"); wait_done(); // R7 timeout, delayed acks
    issue(0, 16'h0022, 16'h3333, 0, 2, 2'd0, "r"); wait_done();  // R8 no response
    issue(0, 16'h0044, 16'h4444, 1, 0, 2'd2, "r"); wait_done();  // R8 failed
    issue(0, 16'h0088, 16'h5555, 0, 3, 2'd3, "r"); wait_done();  // R8 response error
    // R10: request while busy is ignored
    issue(0, 16'h0100, 16'hCAFE, 1, 4, 2'd1, "r");
    tick(); tick();
    issue(1, 16'h7777, 16'hDEAD, 0, 0, 0, "ignored");
    wait_done();
    tick();
    chk(!busy && q.size() == 0, "R10 no extra op", {busy, 31'(q.size())}, 32'h0);
    issue(1, 16'h0002, 16'hF00D, 3, 0, 0, "w"); wait_done();
    repeat (4) tick();
    finish_run();
  end
endmodule